// File: doc/BRIEF.md
# Flat Region Smoothing Filter

This block is the wide smoothing stage of an edge deblocking pipeline. Each beat carries sixteen independent lanes. Every lane holds the eight pixels that straddle one block edge: four on the near side (p3 nearest the outside, then p2, p1, p0) and four on the far side (q0, q1, q2, q3 outward). For each lane the block forms six smoothed pixels, p2 through q2. Each is a weighted sum of the eight taps, rounded and divided by eight. The outermost pixel on each side is replicated to fill out the window.

The same lane also needs a selection among three candidates: the smoothed values, the four results of a narrower filter computed elsewhere, and the untouched input. Two per-lane flags steer that choice, and both are produced upstream. The chosen pixels are captured in an output register. They appear one cycle after the beat together with a valid flag. The register keeps its contents while no beat arrives.

Top module: `flat_smooth_filter`

## Requirements
- R1: While the active-low reset is asserted, outValid is 0 and every output pixel is 0.
- R2: outValid is 1 exactly in the cycle after a cycle with inValid at 1, and 0 after a cycle with inValid at 0.
- R3: For a lane whose flat bit is 1, the outputs are as follows. Every sum is held at 16 bits and the result is (sum + 4) >> 3.
  - p2 = 3·p3 + 2·p2 + p1 + p0 + q0
  - p1 = 2·p3 + p2 + 2·p1 + p0 + q0 + q1
  - p0 = p3 + p2 + p1 + 2·p0 + q0 + q1 + q2
  - q0 = p2 + p1 + p0 + 2·q0 + q1 + q2 + q3
  - q1 = p1 + p0 + q0 + 2·q1 + q2 + 2·q3
  - q2 = p0 + q0 + q1 + 2·q2 + 3·q3
- R4: For a lane with flat 0 and mask 1, the outputs p1, p0, q0 and q1 equal that lane's narrow-filter inputs at the same positions, and p2 and q2 equal their inputs.
- R5: For a lane with both flat and mask at 0, all eight output pixels equal the input pixels.
- R6: Outputs p3 and q3 always equal inputs p3 and q3, whatever the flags.
- R7: The flat bit takes precedence: a lane with flat 1 gets the smoothed values whether its mask bit is 0 or 1.
- R8: In a cycle after one with inValid at 0, every output pixel keeps its previous value.
- R9: Rounding adds 4 before the shift and never overflows. All-255 taps give 255, and a lone far-side 3 among zeros gives 1 at q0 and 0 elsewhere.
- R10: Lanes are independent. Lane j of every input pixel port, narrow port and flag occupies bits [8j+7:8j] (bit j for flags) and drives only lane j of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Beat present on the inputs |
| inP3 | input | LANES*8 | Outermost near-side pixel per lane |
| inP2 | input | LANES*8 | Near-side pixel p2 per lane |
| inP1 | input | LANES*8 | Near-side pixel p1 per lane |
| inP0 | input | LANES*8 | Near-side pixel next to the edge per lane |
| inQ0 | input | LANES*8 | Far-side pixel next to the edge per lane |
| inQ1 | input | LANES*8 | Far-side pixel q1 per lane |
| inQ2 | input | LANES*8 | Far-side pixel q2 per lane |
| inQ3 | input | LANES*8 | Outermost far-side pixel per lane |
| narP1 | input | LANES*8 | Narrow-filter result for p1 |
| narP0 | input | LANES*8 | Narrow-filter result for p0 |
| narQ0 | input | LANES*8 | Narrow-filter result for q0 |
| narQ1 | input | LANES*8 | Narrow-filter result for q1 |
| flatFlag | input | LANES | Per-lane select of smoothed values |
| maskFlag | input | LANES | Per-lane enable of the narrow results |
| outValid | output | 1 | Registered beat valid |
| outP3 | output | LANES*8 | Result p3 |
| outP2 | output | LANES*8 | Result p2 |
| outP1 | output | LANES*8 | Result p1 |
| outP0 | output | LANES*8 | Result p0 |
| outQ0 | output | LANES*8 | Result q0 |
| outQ1 | output | LANES*8 | Result q1 |
| outQ2 | output | LANES*8 | Result q2 |
| outQ3 | output | LANES*8 | Result q3 |

## Verification
The smoothing path and the narrow-result path are both active in a single beat, because the flags are per lane. Every stimulus beat gives lanes 0, 3, 6, and so on the flat bit, gives the next lane in each group mask only, and leaves the third with neither. Lane 15 carries flat with a clear mask. The narrow inputs differ per lane, so a crossed lane or a wrong source shows up. Each lane's eight outputs are judged against values worked out from its own flags: hand-computed smoothed pixels from the table, its own narrow values, or its own inputs.

// File: rtl/flat_smooth_pkg.sv
package flat_smooth_pkg;
  // Window geometry: taps indexed 0 = p3 ... 7 = q3
  localparam int TAPS     = 8;
  localparam int SMOOTH_N = 6;            // p2 .. q2
  localparam int NARROW_N = 4;            // p1 .. q1
  localparam int SMOOTH_LO = (TAPS - SMOOTH_N) / 2;
  localparam int NARROW_LO = (TAPS - NARROW_N) / 2;
  localparam int ROUND_SH = 3;            // divide by eight

  typedef struct packed {
    logic load;                           // capture this beat
  } ctrlStrobe_t;
endpackage

// File: rtl/flat_smooth_taps.sv
module flat_smooth_taps
  import flat_smooth_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SUM_W = 16
) (
  input  logic [TAPS-1:0][PIX_W-1:0]     tapIn,
  output logic [SMOOTH_N-1:0][PIX_W-1:0] smoothOut
);
  localparam logic [SUM_W-1:0] RND = SUM_W'(1 << (ROUND_SH - 1));

  logic [TAPS-1:0][SUM_W-1:0]     wide;
  logic [SMOOTH_N-1:0][SUM_W-1:0] sums;

  for (genvar t = 0; t < TAPS; t++) begin : g_widen
    assign wide[t] = SUM_W'(tapIn[t]);
  end

  // wide[0]=p3 [1]=p2 [2]=p1 [3]=p0 [4]=q0 [5]=q1 [6]=q2 [7]=q3
  always_comb begin
    sums[0] = wide[0] + wide[0] + wide[0] + wide[1] + wide[1]
            + wide[2] + wide[3] + wide[4] + RND;
    sums[1] = wide[0] + wide[0] + wide[1] + wide[2] + wide[2]
            + wide[3] + wide[4] + wide[5] + RND;
    sums[2] = wide[0] + wide[1] + wide[2] + wide[3] + wide[3]
            + wide[4] + wide[5] + wide[6] + RND;
    sums[3] = wide[1] + wide[2] + wide[3] + wide[4] + wide[4]
            + wide[5] + wide[6] + wide[7] + RND;
    sums[4] = wide[2] + wide[3] + wide[4] + wide[5] + wide[5]
            + wide[6] + wide[7] + wide[7] + RND;
    sums[5] = wide[3] + wide[4] + wide[5] + wide[6] + wide[6]
            + wide[7] + wide[7] + wide[7] + RND;
  end

  for (genvar k = 0; k < SMOOTH_N; k++) begin : g_scale
    assign smoothOut[k] = PIX_W'(sums[k] >> ROUND_SH);
  end
endmodule

// File: rtl/flat_smooth_ctrl.sv
module flat_smooth_ctrl
  import flat_smooth_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  assign strobe.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/flat_smooth_datapath.sv
module flat_smooth_datapath
  import flat_smooth_pkg::*;
#(
  parameter int LANES = 16,
  parameter int PIX_W = 8,
  parameter int SUM_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctrlStrobe_t                           strobe,
  input  logic [TAPS-1:0][LANES-1:0][PIX_W-1:0] tapIn,
  input  logic [NARROW_N-1:0][LANES-1:0][PIX_W-1:0] narrowIn,
  input  logic [LANES-1:0]                      flatFlag,
  input  logic [LANES-1:0]                      maskFlag,
  output logic [TAPS-1:0][LANES-1:0][PIX_W-1:0] tapOut
);
  logic [TAPS-1:0][LANES-1:0][PIX_W-1:0] nextTap;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [TAPS-1:0][PIX_W-1:0]     laneTaps;
    logic [SMOOTH_N-1:0][PIX_W-1:0] laneSmooth;

    for (genvar t = 0; t < TAPS; t++) begin : g_gather
      assign laneTaps[t] = tapIn[t][ln];
    end

    flat_smooth_taps #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_taps (
      .tapIn    (laneTaps),
      .smoothOut(laneSmooth)
    );

    for (genvar t = 0; t < TAPS; t++) begin : g_pick
      if (t < SMOOTH_LO || t >= SMOOTH_LO + SMOOTH_N) begin : g_edge
        assign nextTap[t][ln] = tapIn[t][ln];
      end else if (t >= NARROW_LO && t < NARROW_LO + NARROW_N) begin : g_inner
        assign nextTap[t][ln] = flatFlag[ln] ? laneSmooth[t-SMOOTH_LO]
                              : maskFlag[ln] ? narrowIn[t-NARROW_LO][ln]
                              : tapIn[t][ln];
      end else begin : g_outer
        assign nextTap[t][ln] = flatFlag[ln] ? laneSmooth[t-SMOOTH_LO]
                                             : tapIn[t][ln];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tapOut <= '0;
    else if (strobe.load) tapOut <= nextTap;
  end
endmodule

// File: rtl/flat_smooth_filter.sv
module flat_smooth_filter
  import flat_smooth_pkg::*;
#(
  parameter int LANES = 16,
  parameter int PIX_W = 8,
  parameter int SUM_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [LANES-1:0][PIX_W-1:0] inP3,
  input  logic [LANES-1:0][PIX_W-1:0] inP2,
  input  logic [LANES-1:0][PIX_W-1:0] inP1,
  input  logic [LANES-1:0][PIX_W-1:0] inP0,
  input  logic [LANES-1:0][PIX_W-1:0] inQ0,
  input  logic [LANES-1:0][PIX_W-1:0] inQ1,
  input  logic [LANES-1:0][PIX_W-1:0] inQ2,
  input  logic [LANES-1:0][PIX_W-1:0] inQ3,
  input  logic [LANES-1:0][PIX_W-1:0] narP1,
  input  logic [LANES-1:0][PIX_W-1:0] narP0,
  input  logic [LANES-1:0][PIX_W-1:0] narQ0,
  input  logic [LANES-1:0][PIX_W-1:0] narQ1,
  input  logic [LANES-1:0]            flatFlag,
  input  logic [LANES-1:0]            maskFlag,
  output logic                        outValid,
  output logic [LANES-1:0][PIX_W-1:0] outP3,
  output logic [LANES-1:0][PIX_W-1:0] outP2,
  output logic [LANES-1:0][PIX_W-1:0] outP1,
  output logic [LANES-1:0][PIX_W-1:0] outP0,
  output logic [LANES-1:0][PIX_W-1:0] outQ0,
  output logic [LANES-1:0][PIX_W-1:0] outQ1,
  output logic [LANES-1:0][PIX_W-1:0] outQ2,
  output logic [LANES-1:0][PIX_W-1:0] outQ3
);
  ctrlStrobe_t                           strobe;
  logic [TAPS-1:0][LANES-1:0][PIX_W-1:0] tapIn;
  logic [TAPS-1:0][LANES-1:0][PIX_W-1:0] tapOut;
  logic [NARROW_N-1:0][LANES-1:0][PIX_W-1:0] narrowIn;

  assign tapIn    = {inQ3, inQ2, inQ1, inQ0, inP0, inP1, inP2, inP3};
  assign narrowIn = {narQ1, narQ0, narP0, narP1};

  flat_smooth_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  flat_smooth_datapath #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .tapIn   (tapIn),
    .narrowIn(narrowIn),
    .flatFlag(flatFlag),
    .maskFlag(maskFlag),
    .tapOut  (tapOut)
  );

  assign outP3 = tapOut[0];
  assign outP2 = tapOut[1];
  assign outP1 = tapOut[2];
  assign outP0 = tapOut[3];
  assign outQ0 = tapOut[4];
  assign outQ1 = tapOut[5];
  assign outQ2 = tapOut[6];
  assign outQ3 = tapOut[7];
endmodule

// File: rtl/flat_smooth_filter_checker.sv
module flat_smooth_filter_checker #(
  parameter int LANES = 16,
  parameter int PIX_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        inValid,
  input logic [LANES-1:0][PIX_W-1:0] inP3,
  input logic [LANES-1:0][PIX_W-1:0] inP2,
  input logic [LANES-1:0][PIX_W-1:0] inP1,
  input logic [LANES-1:0][PIX_W-1:0] inQ1,
  input logic [LANES-1:0][PIX_W-1:0] inQ2,
  input logic [LANES-1:0][PIX_W-1:0] inQ3,
  input logic [LANES-1:0][PIX_W-1:0] narP1,
  input logic [LANES-1:0][PIX_W-1:0] narQ1,
  input logic [LANES-1:0]            flatFlag,
  input logic [LANES-1:0]            maskFlag,
  input logic                        outValid,
  input logic [LANES-1:0][PIX_W-1:0] outP3,
  input logic [LANES-1:0][PIX_W-1:0] outP2,
  input logic [LANES-1:0][PIX_W-1:0] outP1,
  input logic [LANES-1:0][PIX_W-1:0] outP0,
  input logic [LANES-1:0][PIX_W-1:0] outQ0,
  input logic [LANES-1:0][PIX_W-1:0] outQ1,
  input logic [LANES-1:0][PIX_W-1:0] outQ2,
  input logic [LANES-1:0][PIX_W-1:0] outQ3
);
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outP3) && $stable(outP2) && $stable(outP1) && $stable(outP0)
              && $stable(outQ0) && $stable(outQ1) && $stable(outQ2) && $stable(outQ3));

  assert_edge_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outP3 == $past(inP3)) && (outQ3 == $past(inQ3)));

  assert_plain_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (flatFlag == '0) && (maskFlag == '0)
    |=> (outP2 == $past(inP2)) && (outP1 == $past(inP1))
     && (outQ1 == $past(inQ1)) && (outQ2 == $past(inQ2)));

  assert_narrow_take_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (flatFlag == '0) && (&maskFlag)
    |=> (outP1 == $past(narP1)) && (outQ1 == $past(narQ1))
     && (outP2 == $past(inP2)) && (outQ2 == $past(inQ2)));
endmodule

bind flat_smooth_filter flat_smooth_filter_checker #(.LANES(LANES), .PIX_W(PIX_W)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .inP3(inP3), .inP2(inP2), .inP1(inP1), .inQ1(inQ1), .inQ2(inQ2), .inQ3(inQ3),
  .narP1(narP1), .narQ1(narQ1), .flatFlag(flatFlag), .maskFlag(maskFlag),
  .outValid(outValid), .outP3(outP3), .outP2(outP2), .outP1(outP1), .outP0(outP0),
  .outQ0(outQ0), .outQ1(outQ1), .outQ2(outQ2), .outQ3(outQ3)
);

// File: tb/flat_smooth_filter_test.sv
module flat_smooth_filter_test;
  localparam int LANES = 16;
  localparam int NVEC  = 6;

  // {p3,p2,p1,p0,q0,q1,q2,q3, exp p2,p1,p0,q0,q1,q2}
  localparam logic [13:0][7:0] VEC [NVEC] = '{
    {8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100,
     8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255,
     8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd80, 8'd80, 8'd80, 8'd80,
     8'd10, 8'd20, 8'd30, 8'd50, 8'd60, 8'd70},
    {8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80,
     8'd24, 8'd31, 8'd40, 8'd50, 8'd59, 8'd66},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd0, 8'd0, 8'd0,
     8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd0},
    {8'd200, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,
     8'd75, 8'd50, 8'd25, 8'd0, 8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0][LANES-1:0][7:0] tapDrv = '0;
  logic [3:0][LANES-1:0][7:0] narDrv = '0;
  logic [LANES-1:0] flatDrv = '0;
  logic [LANES-1:0] maskDrv = '0;
  logic [7:0][LANES-1:0][7:0] tapObs;
  logic [7:0][LANES-1:0][7:0] expTap;
  logic outValid;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flat_smooth_filter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inP3(tapDrv[0]), .inP2(tapDrv[1]), .inP1(tapDrv[2]), .inP0(tapDrv[3]),
    .inQ0(tapDrv[4]), .inQ1(tapDrv[5]), .inQ2(tapDrv[6]), .inQ3(tapDrv[7]),
    .narP1(narDrv[0]), .narP0(narDrv[1]), .narQ0(narDrv[2]), .narQ1(narDrv[3]),
    .flatFlag(flatDrv), .maskFlag(maskDrv), .outValid(outValid),
    .outP3(tapObs[0]), .outP2(tapObs[1]), .outP1(tapObs[2]), .outP0(tapObs[3]),
    .outQ0(tapObs[4]), .outQ1(tapObs[5]), .outQ2(tapObs[6]), .outQ3(tapObs[7])
  );

  task automatic check(input string req, input int lane, input int tap,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s lane=%0d tap=%0d actual=%0d expected=%0d", req, lane, tap, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drives one table entry across all lanes with mixed per-lane selection.
  task automatic driveEntry(input int e);
    for (int j = 0; j < LANES; j++) begin
      flatDrv[j] = (j % 3 == 0);
      maskDrv[j] = (j % 3 != 2) && (j != 15);
      for (int m = 0; m < 4; m++) narDrv[m][j] = 8'(160 + 16 * m + j);
      for (int t = 0; t < 8; t++) begin
        tapDrv[t][j] = VEC[e][13 - t];
        if (t == 0 || t == 7)      expTap[t][j] = VEC[e][13 - t];
        else if (flatDrv[j])       expTap[t][j] = VEC[e][6 - t];
        else if (maskDrv[j] && t >= 2 && t <= 5) expTap[t][j] = narDrv[t - 2][j];
        else                       expTap[t][j] = VEC[e][13 - t];
      end
    end
    inValid = 1'b1;
  endtask

  task automatic checkEntry(input int e);
    string req;
    for (int j = 0; j < LANES; j++) begin
      for (int t = 0; t < 8; t++) begin
        if (t == 0 || t == 7)  req = "R6";
        else if (j == 15)      req = "R7";
        else if (flatDrv[j])   req = (e == 1 || e == 4) ? "R9" : "R3";
        else if (maskDrv[j])   req = "R4 R10";
        else                   req = "R5";
        check(req, j, t, tapObs[t][j], expTap[t][j]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkBit("R1 outValid", outValid, 1'b0);
    for (int t = 0; t < 8; t++) check("R1", 0, t, tapObs[t][0], 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: every entry mixes flat, mask-only and plain lanes.
    for (int e = 0; e < NVEC; e++) begin
      driveEntry(e);
      @(negedge clk);
      checkBit("R2 outValid", outValid, 1'b1);
      checkEntry(e);
    end

    // R8: idle cycles with changed inputs leave outputs untouched.
    inValid = 1'b0;
    tapDrv  = {8 * LANES{8'd7}};
    narDrv  = {4 * LANES{8'd9}};
    flatDrv = '0;
    maskDrv = '0;
    repeat (2) @(negedge clk);
    checkBit("R2 drop", outValid, 1'b0);
    for (int j = 0; j < LANES; j++)
      for (int t = 0; t < 8; t++) check("R8", j, t, tapObs[t][j], expTap[t][j]);

    // R7: flat with mask clear in every lane still smooths.
    driveEntry(3);
    maskDrv = '0;
    flatDrv = '1;
    for (int j = 0; j < LANES; j++)
      for (int t = 1; t < 7; t++) expTap[t][j] = VEC[3][6 - t];
    @(negedge clk);
    for (int j = 0; j < LANES; j++)
      for (int t = 1; t < 7; t++) check("R7", j, t, tapObs[t][j], expTap[t][j]);

    // R1: reset in the middle of a run clears the register.
    driveEntry(1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkBit("R1 mid outValid", outValid, 1'b0);
    for (int t = 0; t < 8; t++) check("R1 mid", 5, t, tapObs[t][5], 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule